// File: doc/BRIEF.md
# Transition-Density Loss-of-Signal Monitor with Byte Deserializer

This block sits on the receive side of a serial line, after clock recovery. It takes one received bit per bit-clock cycle and keeps track of how often the data toggles. A long run of identical bits makes it declare that the signal is lost. It withdraws that declaration only after the stream again shows enough transitions inside a sliding window. The gap between the two thresholds gives hysteresis, so a marginal line does not make the flag chatter.

An active-low signal-detect input from the optical module is passed through a synchronizer and ORed with the internal indication. A disable input masks the internal detector, so that the external input alone decides. The same bit stream is also assembled into bytes, most significant bit first, with a one-cycle strobe on every eighth bit. While the combined loss flag is high, the byte output is forced to all zeros.

Top module: `los_monitor`

## Requirements
- R1: During and directly after a synchronous reset, `los` is 1, `rx_word` is 8'h00 and `word_stb` is 0.
- R2: A transition is a received bit that differs from the bit received one cycle earlier. The first bit after reset is compared with 0. The internal loss indication is set on the edge that samples the 129th consecutive bit without a transition. A run of 128 such bits does not set it, and a run of any greater length keeps it set. `los` follows the internal indication one cycle later.
- R3: The internal loss indication is cleared on the edge where the number of transitions among the last 128 sampled bits, counting the current one, reaches 16. A steady pattern of one transition every 8 bits therefore clears it, and one transition every 9 or more bits does not. `los` follows one cycle later.
- R4: While `int_det_off` is 1, the internal indication cannot raise `los`. The input takes effect on `los` at the very next clock edge.
- R5: `ext_sd_n` is active low. It passes two synchronizer flops, so a low level sampled on edge k makes `los` 1 after edge k+2, whatever the data stream is doing.
- R6: `los` is the OR of the (unmasked) internal indication and the synchronized external loss. It is 0 only when both are inactive.
- R7: Bits are packed most significant bit first. The first bit sampled after reset lands in bit 7. On the edge that samples every 8th bit counted from reset, `word_stb` pulses high for one cycle and `rx_word` takes the new byte. `rx_word` then holds that byte until the next strobe.
- R8: In every cycle in which `los` is 1, `rx_word` is 8'h00. When `los` falls, the most recently assembled byte appears again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one received bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Received serial data bit |
| int_det_off | input | 1 | 1 masks the internal transition-based detector |
| ext_sd_n | input | 1 | External signal detect, low means loss |
| rx_word | output | 8 | Assembled byte, zero while loss is flagged |
| word_stb | output | 1 | One-cycle pulse when a new byte is loaded |
| los | output | 1 | Combined loss-of-signal flag |

## Verification
The bench sweeps quiet-run lengths from 126 to 131 bits. A detector that is one bit off in either direction declares loss after 128 bits or waits until 130, and the sweep catches both. It then sweeps the transition spacing from 1 to 10 bits after a loss. A window count that does not subtract the flags leaving the window, or that compares with the wrong threshold, clears at spacing 9 or stays stuck at spacing 8. Separate cases check the synchronizer latency of the external input, the masking by the disable input while data is quiet, and a 1000-bit quiet run that would expose a run counter that wraps instead of saturating. Byte order, strobe alignment and the all-zero squelch are compared against a bench model on every cycle.

// File: rtl/los_pkg.sv
package los_pkg;
  localparam int unsigned DEF_WORD_W    = 8;
  localparam int unsigned DEF_LOSS_RUN  = 128;
  localparam int unsigned DEF_WIN_LEN   = 128;
  localparam int unsigned DEF_MIN_EDGES = 16;

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_INT  = 2'b01,
    SRC_EXT  = 2'b10,
    SRC_BOTH = 2'b11
  } los_src_e;

  function automatic los_src_e merge_src(input logic int_loss, input logic ext_loss);
    return los_src_e'({ext_loss, int_loss});
  endfunction
endpackage

// File: rtl/los_run_detector.sv
module los_run_detector #(
  parameter int unsigned LOSS_RUN = 128,
  localparam int unsigned RUN_W = $clog2(LOSS_RUN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_in,
  output logic quiet_expired
);
  logic [RUN_W-1:0] run_cnt;
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(LOSS_RUN);

  // Fires on the bit that extends a full quiet run by one more quiet bit.
  assign quiet_expired = !edge_in && (run_cnt == RUN_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
    end else if (edge_in) begin
      run_cnt <= '0;
    end else if (run_cnt != RUN_MAX) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  always_comb begin
    if (!rst) a_r2_run_saturates: assert (run_cnt <= RUN_MAX);
  end
endmodule

// File: rtl/los_edge_window.sv
module los_edge_window #(
  parameter int unsigned WIN_LEN   = 128,
  parameter int unsigned MIN_EDGES = 16,
  localparam int unsigned CNT_W = $clog2(WIN_LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_in,
  output logic dense
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             leaving;

  generate
    if (WIN_LEN > 1) begin : g_shift
      logic [WIN_LEN-1:0] flags;
      assign leaving = flags[WIN_LEN-1];
      always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= {flags[WIN_LEN-2:0], edge_in};
      end
    end else begin : g_single
      logic flag;
      assign leaving = flag;
      always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= edge_in;
      end
    end
  endgenerate

  assign cnt_d = cnt_q + CNT_W'(edge_in) - CNT_W'(leaving);
  assign dense = (cnt_d >= CNT_W'(MIN_EDGES));

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  always_comb begin
    if (!rst) a_r3_count_in_range: assert (cnt_q <= CNT_W'(WIN_LEN));
  end
endmodule

// File: rtl/los_deser.sv
module los_deser #(
  parameter int unsigned WORD_W = 8,
  localparam int unsigned POS_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_in,
  input  logic              squelch_d,
  output logic [WORD_W-1:0] word_q,
  output logic              stb_q
);
  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] raw_q;
  logic [WORD_W-1:0] assembled;
  logic [POS_W-1:0]  pos_q;
  logic              load;

  localparam logic [POS_W-1:0] POS_LAST = POS_W'(WORD_W - 1);

  generate
    if (WORD_W > 1) begin : g_wide
      assign assembled = {sh_q[WORD_W-2:0], bit_in};
    end else begin : g_narrow
      assign assembled = bit_in;
    end
  endgenerate

  assign load = (pos_q == POS_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      raw_q  <= '0;
      pos_q  <= '0;
      stb_q  <= 1'b0;
      word_q <= '0;
    end else begin
      sh_q  <= assembled;
      pos_q <= load ? '0 : pos_q + 1'b1;
      stb_q <= load;
      if (load) raw_q <= assembled;
      if (squelch_d)  word_q <= '0;
      else if (load)  word_q <= assembled;
      else            word_q <= raw_q;
    end
  end

  a_r7_strobe_isolated: assert property (@(posedge clk) disable iff (rst)
    stb_q |=> !stb_q);
endmodule

// File: rtl/los_monitor.sv
module los_monitor #(
  parameter int unsigned WORD_W    = los_pkg::DEF_WORD_W,
  parameter int unsigned LOSS_RUN  = los_pkg::DEF_LOSS_RUN,
  parameter int unsigned WIN_LEN   = los_pkg::DEF_WIN_LEN,
  parameter int unsigned MIN_EDGES = los_pkg::DEF_MIN_EDGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_bit,
  input  logic              int_det_off,
  input  logic              ext_sd_n,
  output logic [WORD_W-1:0] rx_word,
  output logic              word_stb,
  output logic              los
);
  import los_pkg::*;

  logic prev_bit;
  logic bit_edge;
  logic quiet_expired;
  logic dense;
  logic int_loss_q;
  logic ext_meta_q;
  logic ext_sync_q;
  logic los_d;
  logic los_q;
  los_src_e src;

  assign bit_edge = rx_bit ^ prev_bit;

  always_ff @(posedge clk) begin
    if (rst) prev_bit <= 1'b0;
    else     prev_bit <= rx_bit;
  end

  los_run_detector #(.LOSS_RUN(LOSS_RUN)) u_run (
    .clk(clk), .rst(rst), .edge_in(bit_edge), .quiet_expired(quiet_expired)
  );

  los_edge_window #(.WIN_LEN(WIN_LEN), .MIN_EDGES(MIN_EDGES)) u_win (
    .clk(clk), .rst(rst), .edge_in(bit_edge), .dense(dense)
  );

  always_ff @(posedge clk) begin
    if (rst)                int_loss_q <= 1'b1;
    else if (quiet_expired) int_loss_q <= 1'b1;
    else if (dense)         int_loss_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_meta_q <= 1'b1;
      ext_sync_q <= 1'b1;
    end else begin
      ext_meta_q <= ext_sd_n;
      ext_sync_q <= ext_meta_q;
    end
  end

  assign src   = merge_src(int_loss_q && !int_det_off, !ext_sync_q);
  assign los_d = (src != SRC_NONE);

  always_ff @(posedge clk) begin
    if (rst) los_q <= 1'b1;
    else     los_q <= los_d;
  end

  los_deser #(.WORD_W(WORD_W)) u_deser (
    .clk(clk), .rst(rst), .bit_in(rx_bit), .squelch_d(los_d & ~rst),
    .word_q(rx_word), .stb_q(word_stb)
  );

  assign los = los_q;

  a_r5_ext_forces_loss: assert property (@(posedge clk) disable iff (rst)
    !ext_sync_q |=> los_q);
  a_r8_squelched_word: assert property (@(posedge clk) disable iff (rst)
    los_q |-> (rx_word == '0));
  a_r2_quiet_sets_loss: assert property (@(posedge clk) disable iff (rst)
    quiet_expired |=> int_loss_q);
  a_r6_clear_needs_both: assert property (@(posedge clk) disable iff (rst)
    !los_q |-> ext_sync_q || $past(ext_sync_q) || $past(rst));
endmodule

// File: tb/tb_los_monitor.sv
module tb_los_monitor;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_bit = 1'b0;
  logic       int_det_off = 1'b0;
  logic       ext_sd_n = 1'b1;
  logic [7:0] rx_word;
  logic       word_stb;
  logic       los;

  always #2.5 clk = ~clk;

  los_monitor dut (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .int_det_off(int_det_off),
    .ext_sd_n(ext_sd_n), .rx_word(rx_word), .word_stb(word_stb), .los(los)
  );

  int n_checks = 0;
  int n_fail = 0;
  string cur_req = "R1";
  bit cur_bit = 1'b0;

  // bench model
  bit ehist [256];
  int nb;
  bit m_prev, m_int, m_s1, m_s2, m_los, m_stb;
  int m_pos;
  bit [7:0] m_sh, m_raw, m_word;

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    nb = 0; m_prev = 0; m_int = 1; m_s1 = 1; m_s2 = 1; m_los = 1;
    m_stb = 0; m_pos = 0; m_sh = 0; m_raw = 0; m_word = 0; cur_bit = 0;
  endtask

  task automatic model_edge(bit b, bit off, bit extn);
    bit e, nint, nlos, load;
    int quiet, sum, lim;
    bit [7:0] asm_w;
    e = b ^ m_prev;
    m_prev = b;
    ehist[nb % 256] = e;
    nb++;
    quiet = 0;
    while (quiet < nb && quiet < 130 && ehist[(nb - 1 - quiet) % 256] == 1'b0) quiet++;
    sum = 0;
    lim = (nb < 128) ? nb : 128;
    for (int i = 0; i < lim; i++) sum += ehist[(nb - 1 - i) % 256];
    nint = (quiet >= 129) ? 1'b1 : ((sum >= 16) ? 1'b0 : m_int);
    nlos = (m_int & ~off) | ~m_s2;
    m_s2 = m_s1; m_s1 = extn; m_int = nint; m_los = nlos;
    asm_w = {m_sh[6:0], b};
    load = (m_pos == 7);
    m_sh = asm_w;
    m_pos = load ? 0 : m_pos + 1;
    if (load) m_raw = asm_w;
    m_stb = load;
    m_word = nlos ? 8'h00 : m_raw;
  endtask

  task automatic step(bit b);
    rx_bit = b;
    cur_bit = b;
    @(posedge clk);
    #1;
    model_edge(b, int_det_off, ext_sd_n);
    check(cur_req, "los", los, m_los);
    check("R7", "word_stb", word_stb, m_stb);
    check(m_los ? "R8" : "R7", "rx_word", rx_word, m_word);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    int_det_off = 0; ext_sd_n = 1; rx_bit = 0;
    repeat (3) @(posedge clk);
    #1;
    model_reset();
    check("R1", "los in reset", los, 1);
    check("R1", "rx_word in reset", rx_word, 0);
    check("R1", "word_stb in reset", word_stb, 0);
    rst = 1'b0;
  endtask

  task automatic lock_run(int n);
    for (int i = 0; i < n; i++) step(~cur_bit);
  endtask

  task automatic quiet_run(int n);
    for (int i = 0; i < n; i++) step(cur_bit);
  endtask

  task automatic spaced_run(int n, int spacing);
    for (int i = 0; i < n; i++) step((i % spacing == spacing - 1) ? ~cur_bit : cur_bit);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    bit [7:0] pat;
    do_reset();

    // R1: squelch holds right after reset until clearing condition
    cur_req = "R1";
    step(1'b0);
    check("R1", "los after first bit", los, 1);

    // R3: alternating data clears loss
    cur_req = "R3";
    lock_run(48);
    check("R3", "los after alternating bits", los, 0);

    // R7: byte order, aligned to the strobe grid
    cur_req = "R7";
    while (nb % 8 != 0) step(~cur_bit);
    pat = 8'hB4;
    for (int i = 7; i >= 0; i--) step(pat[i]);
    check("R7", "strobe on 8th bit", word_stb, 1);
    check("R7", "byte MSB first", rx_word, 8'hB4);
    step(~cur_bit);
    check("R7", "strobe drops", word_stb, 0);

    // R2: quiet-run length sweep around the threshold
    cur_req = "R2";
    for (int len = 126; len <= 131; len++) begin
      lock_run(48);
      quiet_run(len);
      step(~cur_bit);
      check("R2", $sformatf("los after quiet %0d", len), los, (len >= 129) ? 1 : 0);
    end
    lock_run(48);
    quiet_run(1000);
    check("R2", "los after long quiet run", los, 1);

    // R3: transition spacing sweep for recovery
    cur_req = "R3";
    for (int s = 1; s <= 10; s++) begin
      quiet_run(200);
      spaced_run(256, s);
      check("R3", $sformatf("los with spacing %0d", s), los, (s > 8) ? 1 : 0);
    end

    // R4: disable masks internal detector while data is quiet
    cur_req = "R4";
    lock_run(48);
    if (cur_bit == 1'b0) step(1'b1);
    quiet_run(200);
    int_det_off = 1'b1;
    step(cur_bit);
    check("R4", "los masked next edge", los, 0);
    while (nb % 8 != 0) step(cur_bit);
    check("R8", "quiet ones pass when masked", rx_word, 8'hFF);
    int_det_off = 1'b0;
    step(cur_bit);
    check("R4", "los returns on unmask", los, 1);

    // R5/R6/R8: external detect
    cur_req = "R5";
    lock_run(48);
    ext_sd_n = 1'b0;
    step(~cur_bit);
    step(~cur_bit);
    check("R5", "los not yet at edge k+1", los, 0);
    step(~cur_bit);
    check("R5", "los at edge k+2", los, 1);
    lock_run(40);
    check("R8", "word zero during external loss", rx_word, 0);
    cur_req = "R6";
    int_det_off = 1'b1;
    lock_run(8);
    check("R6", "external alone holds los", los, 1);
    ext_sd_n = 1'b1;
    int_det_off = 1'b0;
    lock_run(4);
    check("R6", "los clear when both inactive", los, 0);
    quiet_run(140);
    check("R6", "internal alone raises los", los, 1);

    do_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule